// File: doc/BRIEF.md
# Output Channel Occupancy Load Tracker

This block supports adaptive routing in a network that uses no credits. For every output port it counts the flits that currently sit in a watched stretch of that output's channel. A routing request names the outputs it may use. The block grants the one that carries the least load. The granted output is charged the packet's whole length at once, so the load is visible before the packet's flits reach the watched stretch. Each flit that leaves the stretch raises a one-cycle pulse, and that pulse takes one off the count.

Several requests may arrive in one cycle. They are resolved one after another in the same cycle, in input order, with input 0 first. Each request sees the charges that the requests before it have just made. Two heads arriving together therefore tend to spread over different outputs instead of piling onto the same one. Grants are combinational in the cycle of the request. The counters take all of that cycle's charges and departures at the next clock edge.

Top module: `occ_load_tracker`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every occupancy field reads zero.
- R2: grant_valid[i] is high only when req_valid[i] is high. The port in grant_port field i (bits i*OUT_W upward) then has its allow bit set (req_allow bit i*NUM_OUT+port).
- R3: A request is granted the allowed output whose occupancy is smallest. For this choice, occupancy means the stored count plus the charges made earlier in the same cycle.
- R4: One clock edge after a grant, the granted output's occupancy field (bits o*CNT_W upward) has grown by the request's full length, taken from req_len field i.
- R5: A flit_left[o] pulse lowers output o's occupancy by one at the next edge.
- R6: A charge and a departure on the same output in the same cycle are both applied.
- R7: An occupancy of zero stays at zero when a departure pulse arrives and there is no charge.
- R8: Occupancy clamps at 2^CNT_W-1 and never wraps.
- R9: Requests in one cycle are resolved in increasing input index. A later request sees the charges made by the earlier ones.
- R10: When allowed outputs have equal occupancy, the lowest-numbered one is granted.
- R11: A request with no allowed output, or with req_valid low, gets no grant and charges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_IN | Routing request present, one bit per input |
| req_allow | input | NUM_IN*NUM_OUT | Allowed outputs; bit i*NUM_OUT+o lets input i use output o |
| req_len | input | NUM_IN*LEN_W | Packet length in flits, field i per input |
| flit_left | input | NUM_OUT | One pulse per flit leaving the watched stretch of output o |
| grant_valid | output | NUM_IN | A grant was made for input i this cycle |
| grant_port | output | NUM_IN*OUT_W | Granted output index, field i per input |
| occupancy | output | NUM_OUT*CNT_W | Current count for each output, field o per output |

## Verification
Grants are combinational, so they are due in the same cycle as the request. The bench drives each request 1 ns after a rising edge and reads the grants 1 ns later, well before the next edge. Occupancy changes one edge after the stimulus, so each count check is made 1 ns after the following rising edge. At that moment the inputs for the next step are also applied, and only then. Multi-cycle sequences, such as draining to zero or charging up to the ceiling, are checked one edge at a time. The expected values come from the stated length and pulse counts.

// File: rtl/occ_load_tracker.sv
module occ_load_tracker #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 4,
  parameter int CNT_W   = 6,
  parameter int LEN_W   = 5,
  localparam int OUT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IN-1:0]          req_valid,
  input  logic [NUM_IN*NUM_OUT-1:0]  req_allow,
  input  logic [NUM_IN*LEN_W-1:0]    req_len,
  input  logic [NUM_OUT-1:0]         flit_left,
  output logic [NUM_IN-1:0]          grant_valid,
  output logic [NUM_IN*OUT_W-1:0]    grant_port,
  output logic [NUM_OUT*CNT_W-1:0]   occupancy
);
  localparam int SUM_W = CNT_W + LEN_W + $clog2(NUM_IN + 1) + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q [NUM_OUT];
  logic [CNT_W-1:0] cnt_d [NUM_OUT];

  always_comb begin
    logic [SUM_W-1:0] acc [NUM_OUT];
    logic [SUM_W-1:0] best_v;
    logic [OUT_W-1:0] best_o;
    logic             hit;
    for (int o = 0; o < NUM_OUT; o++) acc[o] = SUM_W'(cnt_q[o]);
    grant_valid = '0;
    grant_port  = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      hit    = 1'b0;
      best_v = '0;
      best_o = '0;
      for (int o = 0; o < NUM_OUT; o++) begin
        if (req_valid[i] && req_allow[i*NUM_OUT+o] && (!hit || acc[o] < best_v)) begin
          hit    = 1'b1;
          best_v = acc[o];
          best_o = OUT_W'(o);
        end
      end
      grant_valid[i]                 = hit;
      grant_port[i*OUT_W +: OUT_W]   = best_o;
      if (hit) acc[best_o] = acc[best_o] + SUM_W'(req_len[i*LEN_W +: LEN_W]);
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      if (flit_left[o] && acc[o] != '0) acc[o] = acc[o] - SUM_W'(1);
      cnt_d[o] = (acc[o] > CAP) ? {CNT_W{1'b1}} : acc[o][CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NUM_OUT; o++) begin
      if (!rst_n) cnt_q[o] <= '0;
      else        cnt_q[o] <= cnt_d[o];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_occ
    assign occupancy[g*CNT_W +: CNT_W] = cnt_q[g];
  end
endmodule

// File: rtl/occ_load_tracker_chk.sv
module occ_load_tracker_chk #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 4,
  parameter int CNT_W   = 6,
  parameter int LEN_W   = 5,
  localparam int OUT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_IN-1:0]          req_valid,
  input logic [NUM_IN*NUM_OUT-1:0]  req_allow,
  input logic [NUM_IN*LEN_W-1:0]    req_len,
  input logic [NUM_OUT-1:0]         flit_left,
  input logic [NUM_IN-1:0]          grant_valid,
  input logic [NUM_IN*OUT_W-1:0]    grant_port,
  input logic [NUM_OUT*CNT_W-1:0]   occupancy
);
  localparam int W = CNT_W + LEN_W + $clog2(NUM_IN + 1) + 2;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [W-1:0]     charge [NUM_OUT];
  logic [CNT_W-1:0] exp_d  [NUM_OUT];
  logic [CNT_W-1:0] exp_q  [NUM_OUT];
  logic             armed;

  always_comb begin
    logic [W-1:0] t;
    for (int o = 0; o < NUM_OUT; o++) begin
      charge[o] = '0;
      for (int i = 0; i < NUM_IN; i++)
        if (grant_valid[i] && int'(grant_port[i*OUT_W +: OUT_W]) == o)
          charge[o] = charge[o] + W'(req_len[i*LEN_W +: LEN_W]);
      t = W'(occupancy[o*CNT_W +: CNT_W]) + charge[o];
      if (flit_left[o] && t != '0) t = t - W'(1);
      exp_d[o] = (t > W'(MAXV)) ? MAXV : t[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    armed <= rst_n;
    for (int o = 0; o < NUM_OUT; o++) exp_q[o] <= exp_d[o];
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> occupancy[g*CNT_W +: CNT_W] == '0);
    assert_count_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> occupancy[g*CNT_W +: CNT_W] == exp_q[g]);
    assert_floor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy[g*CNT_W +: CNT_W] == '0 && flit_left[g] && charge[g] == '0)
      |=> occupancy[g*CNT_W +: CNT_W] == '0);
    assert_ceiling_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy[g*CNT_W +: CNT_W] == MAXV && !flit_left[g])
      |=> occupancy[g*CNT_W +: CNT_W] == MAXV);
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[gi] |-> req_valid[gi]);
    assert_grant_allowed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[gi] |-> req_allow[gi*NUM_OUT + int'(grant_port[gi*OUT_W +: OUT_W])]);
    assert_no_allow_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_allow[gi*NUM_OUT +: NUM_OUT] == '0) |-> !grant_valid[gi]);
  end
endmodule

bind occ_load_tracker occ_load_tracker_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_allow(req_allow),
  .req_len(req_len), .flit_left(flit_left), .grant_valid(grant_valid),
  .grant_port(grant_port), .occupancy(occupancy)
);

// File: tb/tb_occ_load_tracker.sv
`timescale 1ns/1ps
module tb_occ_load_tracker;
  localparam int NI = 3, NO = 4, CW = 6, LW = 5, OW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    req_valid = '0;
  logic [NI*NO-1:0] req_allow = '0;
  logic [NI*LW-1:0] req_len   = '0;
  logic [NO-1:0]    flit_left = '0;
  logic [NI-1:0]    grant_valid;
  logic [NI*OW-1:0] grant_port;
  logic [NO*CW-1:0] occupancy;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  occ_load_tracker #(.NUM_IN(NI), .NUM_OUT(NO), .CNT_W(CW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_allow(req_allow),
    .req_len(req_len), .flit_left(flit_left), .grant_valid(grant_valid),
    .grant_port(grant_port), .occupancy(occupancy));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int occ(int o);
    return int'(occupancy[o*CW +: CW]);
  endfunction

  function automatic int gport(int i);
    return int'(grant_port[i*OW +: OW]);
  endfunction

  task automatic idle();
    req_valid = '0; req_allow = '0; req_len = '0; flit_left = '0;
  endtask

  task automatic req(int i, logic [NO-1:0] allow, int len);
    req_valid[i] = 1'b1;
    req_allow[i*NO +: NO] = allow;
    req_len[i*LW +: LW] = LW'(len);
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int o = 0; o < NO; o++) chk("R1 reset clear", occ(o), 0);
  endtask

  task automatic t_single();
    do_reset();
    req(0, 4'b0110, 5); #1;
    chk("R2 grant valid", int'(grant_valid[0]), 1);
    chk("R10 tie lowest", gport(0), 1);
    edge_step();
    chk("R4 charge length", occ(1), 5);
    req(0, 4'b0110, 3); #1;
    chk("R3 least loaded", gport(0), 2);
    edge_step();
    chk("R4 second charge", occ(2), 3);
    chk("R4 other untouched", occ(1), 5);
  endtask

  task automatic t_chain();
    do_reset();
    req(0, 4'b0011, 4); req(1, 4'b0011, 2); req(2, 4'b0011, 1); #1;
    chk("R9 in0 port", gport(0), 0);
    chk("R9 in1 sees in0", gport(1), 1);
    chk("R9 in2 sees in1", gport(2), 1);
    edge_step();
    chk("R9 occ0", occ(0), 4);
    chk("R9 occ1", occ(1), 3);
    req(0, 4'b0011, 1); #1;
    chk("R3 pick lower load", gport(0), 1);
    edge_step();
  endtask

  task automatic t_ties();
    do_reset();
    req(0, 4'b1100, 2); #1;
    chk("R10 tie at zero", gport(0), 2);
    edge_step();
    req(0, 4'b1000, 2); #1;
    edge_step();
    req(1, 4'b1100, 1); #1;
    chk("R10 tie at two", gport(1), 2);
    edge_step();
  endtask

  task automatic t_no_allow();
    do_reset();
    req(1, 4'b0000, 7); #1;
    chk("R11 empty allow no grant", int'(grant_valid[1]), 0);
    edge_step();
    req_allow[0 +: NO] = 4'b1111; req_len[0 +: LW] = 5'd9; #1;
    chk("R11 invalid no grant", int'(grant_valid[0]), 0);
    edge_step();
    for (int o = 0; o < NO; o++) chk("R11 no charge", occ(o), 0);
  endtask

  task automatic t_drain();
    do_reset();
    req(0, 4'b1000, 3); #1;
    edge_step();
    chk("R4 charged", occ(3), 3);
    for (int k = 2; k >= 0; k--) begin
      flit_left[3] = 1'b1;
      edge_step();
      chk("R5 decrement", occ(3), k);
    end
    flit_left = '1;
    edge_step();
    chk("R7 floor", occ(3), 0);
    chk("R7 floor other", occ(0), 0);
  endtask

  task automatic t_incdec();
    do_reset();
    req(0, 4'b0001, 4); #1;
    edge_step();
    req(0, 4'b0001, 2); flit_left[0] = 1'b1; #1;
    edge_step();
    chk("R6 both applied", occ(0), 5);
    req(2, 4'b0100, 1); flit_left[2] = 1'b1; #1;
    edge_step();
    chk("R6 from zero", occ(2), 0);
  endtask

  task automatic t_ceiling();
    do_reset();
    req(0, 4'b0001, 31); #1; edge_step();
    chk("R8 step1", occ(0), 31);
    req(0, 4'b0001, 31); #1; edge_step();
    chk("R8 step2", occ(0), 62);
    req(0, 4'b0001, 31); #1; edge_step();
    chk("R8 clamp", occ(0), 63);
    req(0, 4'b0001, 31); flit_left[0] = 1'b1; #1; edge_step();
    chk("R8 clamp with dec", occ(0), 63);
    flit_left[0] = 1'b1; edge_step();
    chk("R5 dec from max", occ(0), 62);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_single();
    t_chain();
    t_ties();
    t_no_allow();
    t_drain();
    t_incdec();
    t_ceiling();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule